// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers five single-cycle event pulses into one interrupt request. The five sources are timer A underflow, timer B underflow, the time-of-day alarm, serial-port completion and an external flag pin. Each pulse always leaves a sticky record in a readable status register, whatever the mask. The interrupt request is raised only for events that arrive while their source is enabled.

The block sits on a byte-wide register bus at one register address. A write to that address changes the enable mask. Data bit 7 of the write picks the mode: when it is 1, the bits named in data bits 4..0 are set; when it is 0, those bits are cleared. Mask bits not named keep their value. A read of the same address returns the status byte and, on the clock edge that ends the read, clears every status bit and drops the interrupt request. This is the acknowledge.

The mask cannot be read back. Software can learn its state only from whether events raise the request.

Top module: `intr_flag_ctrl`

## Requirements
- R1: After reset the mask is all zero, the status byte reads 0x00 and `irq` is low.
- R2: A write at the register address with data bit 7 = 1 sets every mask bit whose data bit (4..0) is 1. Other mask bits are unchanged.
- R3: A write at the register address with data bit 7 = 0 clears every mask bit whose data bit (4..0) is 1. Other mask bits are unchanged.
- R4: An event pulse on `src_evt[i]` sets status bit i in the next cycle whatever the mask. The bit positions are: 0 timer A, 1 timer B, 2 alarm, 3 serial, 4 flag pin.
- R5: Status bit 7 (summary) is set in the cycle after an event whose mask bit was 1 in the cycle of the pulse. A mask written in that same cycle takes effect from the next cycle.
- R6: `irq` equals status bit 7.
- R7: A read at the register address returns the status byte in the same cycle. The clock edge that ends the read clears all status bits, including bit 7.
- R8: An event pulsed in the same cycle as a read is not in the returned byte, but it is latched after the clear. Its summary contribution is latched as well.
- R9: Setting a mask bit while its status bit is already set does not set bit 7. Only a later event can set it.
- R10: Status bits 6 and 5 always read as 0. A read at any other address returns 0x00 and clears nothing. A write at any other address leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, acknowledges on the closing edge |
| bus_wdata | input | 8 | Write data: bit 7 selects set or clear, bits 4..0 select mask bits |
| bus_rdata | output | 8 | Status byte when addressed, else 0 |
| src_evt | input | 5 | Single-cycle event pulses, one per source |
| irq | output | 1 | Active-high interrupt request |

## Verification
The hardest state to reach is a read colliding with an event in the same cycle. The bench raises the read strobe and an event pulse on the same falling edge. It checks that the byte read excludes the event and that a second read finds it latched.

The mask has no readback. Each mask pattern is therefore inferred through the summary bit: for every combination of 32 masks and 32 event patterns, the bench clears, programs, pulses and reads. The no-retroactive rule is reached by latching a masked event first and enabling its source afterwards.

// File: rtl/intr_flag_pkg.sv
package intr_flag_pkg;

    localparam int N_SRC     = 5;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int SUM_BIT   = 7;
    localparam int MODE_BIT  = 7;
    localparam int PAD_W     = DATA_W - N_SRC - 1;

    typedef logic [N_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_op_e;

    typedef struct packed {
        logic     set_mode;
        src_vec_t bits;
    } mask_cmd_t;

    typedef struct packed {
        logic     summary;
        src_vec_t flags;
    } status_t;

    function automatic mask_cmd_t decode_cmd(input logic [DATA_W-1:0] d);
        mask_cmd_t c;
        c.set_mode = d[MODE_BIT];
        c.bits     = d[N_SRC-1:0];
        return c;
    endfunction

    function automatic src_vec_t apply_cmd(input src_vec_t cur, input mask_cmd_t c);
        return c.set_mode ? (cur | c.bits) : (cur & ~c.bits);
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input status_t s);
        return {s.summary, {PAD_W{1'b0}}, s.flags};
    endfunction

endpackage

// File: rtl/intr_bus_decode.sv
module intr_bus_decode
    import intr_flag_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'hD
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_op_e           op
);
    logic hit;
    assign hit = (bus_addr == REG_ADDR);

    always_comb begin
        op = BUS_IDLE;
        if (hit && bus_wr)      op = BUS_WRITE;
        else if (hit && bus_rd) op = BUS_READ;
    end
endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg
    import intr_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output src_vec_t          mask_q
);
    mask_cmd_t cmd;
    assign cmd = decode_cmd(wdata);

    always_ff @(posedge clk) begin
        if (rst)         mask_q <= '0;
        else if (wr_hit) mask_q <= apply_cmd(mask_q, cmd);
    end
endmodule

// File: rtl/intr_status_reg.sv
module intr_status_reg
    import intr_flag_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ack,
    input  src_vec_t evt,
    input  src_vec_t mask,
    output status_t  stat_q
);
    genvar gi;
    generate
        for (gi = 0; gi < N_SRC; gi++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) stat_q.flags[gi] <= 1'b0;
                else     stat_q.flags[gi] <= (stat_q.flags[gi] & ~ack) | evt[gi];
            end
        end
    endgenerate

    logic live_hit;
    assign live_hit = |(evt & mask);

    always_ff @(posedge clk) begin
        if (rst) stat_q.summary <= 1'b0;
        else     stat_q.summary <= (stat_q.summary & ~ack) | live_hit;
    end
endmodule

// File: rtl/intr_flag_ctrl.sv
module intr_flag_ctrl
    import intr_flag_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'hD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_evt,
    output logic              irq
);
    bus_op_e  op;
    src_vec_t mask_q;
    status_t  stat_q;

    intr_bus_decode #(.REG_ADDR(REG_ADDR)) u_dec (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .op       (op)
    );

    intr_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (op == BUS_WRITE),
        .wdata  (bus_wdata),
        .mask_q (mask_q)
    );

    intr_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .ack    (op == BUS_READ),
        .evt    (src_evt),
        .mask   (mask_q),
        .stat_q (stat_q)
    );

    assign bus_rdata = (op == BUS_READ) ? pack_status(stat_q) : '0;
    assign irq       = stat_q.summary;
endmodule

// File: rtl/intr_flag_chk.sv
module intr_flag_chk
    import intr_flag_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [N_SRC-1:0]  src_evt,
    input logic              irq,
    input logic [N_SRC-1:0]  mask_q
);
    logic rd_hit, wr_hit;
    assign rd_hit = bus_rd && !bus_wr && (bus_addr == 4'hD);
    assign wr_hit = bus_wr && (bus_addr == 4'hD);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && !irq));

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && bus_wdata[7]) |=>
            ((mask_q & $past(bus_wdata[4:0])) == $past(bus_wdata[4:0])));

    assert_mask_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !bus_wdata[7]) |=> ((mask_q & $past(bus_wdata[4:0])) == '0));

    assert_summary_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(|(src_evt & mask_q)));

    assert_no_retro_R9: assert property (@(posedge clk) disable iff (rst)
        (!irq && !(|(src_evt & mask_q))) |=> !irq);

    assert_ack_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !(|(src_evt & mask_q))) |=> !irq);

    assert_pad_zero_R10: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[6:5] == 2'b00);

    assert_summary_bit_R6: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> (bus_rdata[7] == irq));

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(mask_q));
endmodule

bind intr_flag_ctrl intr_flag_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_evt   (src_evt),
    .irq       (irq),
    .mask_q    (mask_q)
);

// File: tb/sim_intr_flag_ctrl.sv
`timescale 1ns/1ps
module sim_intr_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = 4'hD;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [4:0] src_evt = 5'h0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intr_flag_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_evt(src_evt), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_addr = 4'hD;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; bus_addr = 4'hD;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk); src_evt = e;
        @(negedge clk); src_evt = 5'h0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd(4'hD, v); check("R1 status", v, 8'h00);
        pulse(5'h1F); rd(4'hD, v);
        check("R1 mask zero after reset", v, 8'h1F);

        // R2 R4 R5 R6 R7: sweep all masks against all event patterns
        for (int m = 0; m < 32; m++) begin
            for (int e = 0; e < 32; e++) begin
                logic [7:0] exp;
                wr(4'hD, 8'h1F);
                wr(4'hD, 8'h80 | 8'(m));
                rd(4'hD, v);
                pulse(5'(e));
                exp = {(|(5'(m) & 5'(e))), 2'b00, 5'(e)};
                #1 check("R6 irq follows summary", {7'd0, irq}, {7'd0, exp[7]});
                rd(4'hD, v);
                check("R2 R4 R5 status", v, exp);
                #1 check("R7 irq cleared", {7'd0, irq}, 8'h00);
                rd(4'hD, v);
                check("R7 status cleared", v, 8'h00);
            end
        end

        // R3: clear mode leaves unnamed bits alone
        wr(4'hD, 8'h9F);
        wr(4'hD, 8'h05);
        for (int b = 0; b < 5; b++) begin
            logic [7:0] exp;
            pulse(5'(1 << b));
            rd(4'hD, v);
            exp = {(b == 1 || b == 3 || b == 4), 2'b00, 5'(1 << b)};
            check("R3 clear mode", v, exp);
        end

        // R8: event in the same cycle as a read
        wr(4'hD, 8'h9F);
        pulse(5'h02);
        @(negedge clk); bus_rd = 1'b1; src_evt = 5'h08; #1 v = bus_rdata;
        check("R8 read returns old", v, 8'h82);
        @(negedge clk); bus_rd = 1'b0; src_evt = 5'h0;
        rd(4'hD, v);
        check("R8 event kept after clear", v, 8'h88);

        // R5: mask written in the same cycle as the event uses old mask
        wr(4'hD, 8'h1F);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = 8'h81; src_evt = 5'h01;
        @(negedge clk); bus_wr = 1'b0; src_evt = 5'h0;
        rd(4'hD, v);
        check("R5 same-cycle mask write", v, 8'h01);
        wr(4'hD, 8'h1F);

        // R9: no retroactive summary
        pulse(5'h04);
        wr(4'hD, 8'h84);
        repeat (2) @(negedge clk);
        #1 check("R9 irq stays low", {7'd0, irq}, 8'h00);
        rd(4'hD, v);
        check("R9 status", v, 8'h04);
        pulse(5'h04);
        rd(4'hD, v);
        check("R9 new event asserts", v, 8'h84);

        // R10: other addresses
        wr(4'hD, 8'h1F);
        wr(4'hC, 8'h9F);
        pulse(5'h10);
        rd(4'hC, v);
        check("R10 other address reads zero", v, 8'h00);
        rd(4'hD, v);
        check("R10 no clear and no mask change", v, 8'h10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule